// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter

This block turns characters into asynchronous serial frames on a single output line. A character is written into a one-entry holding buffer with a write strobe. At the next bit boundary it moves into a frame shift register and is sent out. While that frame is on the line, the buffer can already accept the following character. Bit timing comes from a pulse input driven by an external baud generator. Every sixteen of those pulses (the oversampling ratio, a parameter) make one bit period.

The frame format is chosen by five configuration inputs, which are sampled when a character is loaded:
- character length: 7 or 8 data bits;
- parity on or off;
- parity sense: even or odd;
- one or two stop bits;
- which flag drives the interrupt.

Two status flags are reported. The holding buffer empty flag and the shift complete (line idle) flag. A one-cycle interrupt pulse follows the rising edge of whichever flag is selected.

Top module: `sertx_core`

## Requirements
- R1: While and after reset, with no write: `txd` = 1, `tbe` = 1, `tsc` = 1, `tx_irq` = 0.
- R2: A frame is sent in this order:
  - a start bit driven 0;
  - the data bits, least significant bit first: 8 bits of `wr_data` when `cfg_len8` = 1, otherwise bits 6..0 only (bit 7 is not sent);
  - a parity bit, only when `cfg_par_en` = 1;
  - one stop bit driven 1, or two when `cfg_two_stop` = 1.
- R3: The parity bit is the XOR of the data bits sent, XORed with `cfg_par_odd`. So 0 gives even and 1 gives odd parity over data plus parity.
- R4: Every bit of a frame lasts exactly OVERSAMPLE pulses of `baud_tick`.
- R5: `tbe` is 0 in the cycle after a write strobe. It returns to 1 when the buffered character moves into the shift register.
- R6: After a write to an idle transmitter, the load waits for the next bit boundary of the free-running divider. `tsc` falls 1 to OVERSAMPLE ticks later, in the same cycle that `tbe` rises.
- R7: `tsc` rises when the last stop bit ends with the buffer empty. In two-stop mode that is the end of the second stop bit. While `tsc` = 1, `txd` stays 1.
- R8: If the buffer holds a character when the last stop bit ends, that character's start bit follows with no idle bit, and `tsc` stays 0.
- R9: `tx_irq` is a one-cycle pulse. It follows each rising edge of `tbe` when `cfg_irq_on_tsc` = 0, and of `tsc` when it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse from the baud generator |
| wr_en | input | 1 | Buffer write strobe |
| wr_data | input | CHAR_W | Character to send |
| cfg_len8 | input | 1 | 1: full-width character, 0: one bit shorter |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even |
| cfg_two_stop | input | 1 | 1: two stop bits |
| cfg_irq_on_tsc | input | 1 | Interrupt source: 1 shift complete, 0 buffer empty |
| txd | output | 1 | Serial output, idles high |
| tbe | output | 1 | Holding buffer empty |
| tsc | output | 1 | Shift complete, line idle |
| tx_irq | output | 1 | Transmit interrupt pulse |

## Verification
The assertions assume two things:
- software writes only while `tbe` = 1, so a write never meets a pending load;
- the configuration changes only while both flags are high.

Without these, the pairing of a falling `tsc` with a rising `tbe` would not hold. The stimulus keeps to both rules: the write task waits for `tbe` before it strobes, and the configuration (including the interrupt source) is re-drawn only after an idle wait. The random gaps between writes still let loads land at every divider phase and in back-to-back chains.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
   // Frame format captured at the moment a character is loaded
   typedef struct packed {
      logic len8;
      logic par_en;
      logic par_odd;
      logic two_stop;
   } sertx_fmt_t;
endpackage

// File: rtl/sertx_bitclk.sv
module sertx_bitclk #(
   parameter int OVERSAMPLE = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic baud_tick,
   output logic bit_strobe
);
   localparam int DW = (OVERSAMPLE > 2) ? $clog2(OVERSAMPLE) : 1;
   localparam bit POW2 = ((OVERSAMPLE & (OVERSAMPLE - 1)) == 0);

   if (OVERSAMPLE < 2) begin : g_bad_os
      $error("sertx_bitclk: OVERSAMPLE must be at least 2");
   end

   logic [DW-1:0] phase_q;

   if (POW2) begin : g_wrap
      // power of two: the counter simply wraps
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         phase_q <= '0;
         else if (baud_tick) phase_q <= phase_q + 1'b1;
      end
      assign bit_strobe = baud_tick && (phase_q == '1);
   end else begin : g_cmp
      // other ratios: compare against the terminal count
      localparam logic [DW-1:0] LAST = DW'(OVERSAMPLE - 1);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) phase_q <= '0;
         else if (baud_tick) phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
      end
      assign bit_strobe = baud_tick && (phase_q == LAST);
   end
endmodule

// File: rtl/sertx_framer.sv
module sertx_framer
   import sertx_pkg::*;
#(
   parameter int CHAR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_strobe,
   input  logic              wr_en,
   input  logic [CHAR_W-1:0] wr_data,
   input  sertx_fmt_t        fmt,
   output logic              txd,
   output logic              tbe,
   output logic              tsc
);
   localparam int FRAME_W = CHAR_W + 4;          // start + data + parity + 2 stop
   localparam int CNT_W   = $clog2(FRAME_W + 1);

   logic [CHAR_W-1:0]  hold_q;
   logic               full_q;
   logic [FRAME_W-1:0] sh_q;       // bits still to follow the current one
   logic [CNT_W-1:0]   left_q;     // bits remaining including the current one
   logic               txd_q;

   logic [FRAME_W-1:0] frame;
   logic [CHAR_W-1:0]  data_m;
   logic               par_bit;
   int                 n_data;
   int                 n_total;

   always_comb begin
      n_data  = fmt.len8 ? CHAR_W : CHAR_W - 1;
      data_m  = fmt.len8 ? hold_q : {1'b0, hold_q[CHAR_W-2:0]};
      par_bit = (^data_m) ^ fmt.par_odd;
      frame   = '1;
      frame[0] = 1'b0;
      for (int j = 1; j <= CHAR_W; j++)
         if (j <= n_data) frame[j] = hold_q[j-1];
      for (int j = 1; j < FRAME_W; j++)
         if (fmt.par_en && (j == n_data + 1)) frame[j] = par_bit;
      n_total = 2 + n_data + (fmt.par_en ? 1 : 0) + (fmt.two_stop ? 1 : 0);
   end

   logic at_end;
   logic load;
   assign at_end = (left_q <= CNT_W'(1));
   assign load   = bit_strobe && at_end && full_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '1;
         left_q <= '0;
         txd_q  <= 1'b1;
      end else if (bit_strobe) begin
         if (!at_end) begin
            txd_q  <= sh_q[0];
            sh_q   <= {1'b1, sh_q[FRAME_W-1:1]};
            left_q <= left_q - 1'b1;
         end else if (full_q) begin
            txd_q  <= frame[0];
            sh_q   <= {1'b1, frame[FRAME_W-1:1]};
            left_q <= CNT_W'(n_total);
         end else begin
            txd_q  <= 1'b1;
            left_q <= '0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
         full_q <= 1'b0;
      end else if (wr_en) begin
         hold_q <= wr_data;
         full_q <= 1'b1;
      end else if (load) begin
         full_q <= 1'b0;
      end
   end

   assign txd = txd_q;
   assign tbe = !full_q;
   assign tsc = (left_q == '0);
endmodule

// File: rtl/sertx_irqsel.sv
module sertx_irqsel (
   input  logic clk,
   input  logic rst_n,
   input  logic tbe,
   input  logic tsc,
   input  logic sel_tsc,
   output logic irq
);
   logic tbe_p, tsc_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tbe_p <= 1'b1;
         tsc_p <= 1'b1;
      end else begin
         tbe_p <= tbe;
         tsc_p <= tsc;
      end
   end

   assign irq = sel_tsc ? (tsc && !tsc_p) : (tbe && !tbe_p);
endmodule

// File: rtl/sertx_core.sv
module sertx_core
   import sertx_pkg::*;
#(
   parameter int OVERSAMPLE = 16,
   parameter int CHAR_W     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic              wr_en,
   input  logic [CHAR_W-1:0] wr_data,
   input  logic              cfg_len8,
   input  logic              cfg_par_en,
   input  logic              cfg_par_odd,
   input  logic              cfg_two_stop,
   input  logic              cfg_irq_on_tsc,
   output logic              txd,
   output logic              tbe,
   output logic              tsc,
   output logic              tx_irq
);
   if (CHAR_W < 2) begin : g_bad_w
      $error("sertx_core: CHAR_W must be at least 2");
   end

   logic       bit_strobe;
   sertx_fmt_t fmt;

   assign fmt = '{len8: cfg_len8, par_en: cfg_par_en,
                  par_odd: cfg_par_odd, two_stop: cfg_two_stop};

   sertx_bitclk #(.OVERSAMPLE(OVERSAMPLE)) u_bitclk (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .bit_strobe(bit_strobe)
   );

   sertx_framer #(.CHAR_W(CHAR_W)) u_framer (
      .clk(clk), .rst_n(rst_n), .bit_strobe(bit_strobe),
      .wr_en(wr_en), .wr_data(wr_data), .fmt(fmt),
      .txd(txd), .tbe(tbe), .tsc(tsc)
   );

   sertx_irqsel u_irqsel (
      .clk(clk), .rst_n(rst_n), .tbe(tbe), .tsc(tsc),
      .sel_tsc(cfg_irq_on_tsc), .irq(tx_irq)
   );
endmodule

// File: rtl/sertx_core_chk.sv
module sertx_core_chk (
   input logic clk,
   input logic rst_n,
   input logic wr_en,
   input logic cfg_irq_on_tsc,
   input logic txd,
   input logic tbe,
   input logic tsc,
   input logic tx_irq
);
   a_r7_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
      tsc |-> txd);

   a_r5_write_clears_tbe: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !tbe);

   a_r6_load_pairs_flags: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tsc) |-> $rose(tbe));

   a_r7_done_buffer_empty: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tsc) |-> (txd && tbe));

   a_r9_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      tx_irq |=> !tx_irq);

   a_r9_irq_source_high: assert property (@(posedge clk) disable iff (!rst_n)
      tx_irq |-> (cfg_irq_on_tsc ? tsc : tbe));
endmodule

bind sertx_core sertx_core_chk u_sertx_core_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .cfg_irq_on_tsc(cfg_irq_on_tsc),
   .txd(txd), .tbe(tbe), .tsc(tsc), .tx_irq(tx_irq)
);

// File: tb/sertx_core_bench.sv
`timescale 1ns/1ps
module sertx_core_bench;
   localparam int OS   = 16;
   localparam int CW   = 8;
   localparam int BIT  = 2 * OS;   // baud_tick every second clock
   localparam int HALF = BIT / 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic baud_tick = 1'b0;
   logic wr_en = 1'b0;
   logic [CW-1:0] wr_data = '0;
   logic cfg_len8 = 1'b1, cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
   logic cfg_two_stop = 1'b0, cfg_irq_on_tsc = 1'b0;
   logic txd, tbe, tsc, tx_irq;

   int checks = 0, errors = 0;
   int cyc = 0, irq_cnt = 0, tsc_rises = 0, sent = 0, frames_seen = 0;
   logic [11:0] eq_bits[$];
   int eq_n[$];
   int start_cyc[$];
   logic tsc_prev = 1'b1;

   sertx_core #(.OVERSAMPLE(OS), .CHAR_W(CW)) u_sertx_core (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en),
      .wr_data(wr_data), .cfg_len8(cfg_len8), .cfg_par_en(cfg_par_en),
      .cfg_par_odd(cfg_par_odd), .cfg_two_stop(cfg_two_stop),
      .cfg_irq_on_tsc(cfg_irq_on_tsc), .txd(txd), .tbe(tbe), .tsc(tsc),
      .tx_irq(tx_irq)
   );

   always #2.5 clk = ~clk;
   always @(negedge clk) baud_tick <= ~baud_tick;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (rst_n && tx_irq) irq_cnt <= irq_cnt + 1;
      if (rst_n && tsc && !tsc_prev) tsc_rises <= tsc_rises + 1;
      tsc_prev <= tsc;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic void build(input logic [7:0] d, output logic [11:0] v,
                                 output int n);
      int nd;
      logic p;
      nd = cfg_len8 ? 8 : 7;
      v = '1;
      v[0] = 1'b0;
      p = cfg_par_odd;
      for (int i = 0; i < nd; i++) begin
         v[1+i] = d[i];
         p ^= d[i];
      end
      n = 1 + nd;
      if (cfg_par_en) begin
         v[n] = p;
         n++;
      end
      n += cfg_two_stop ? 2 : 1;
   endfunction

   task automatic send(input logic [7:0] d);
      logic [11:0] v;
      int n;
      @(negedge clk);
      while (!tbe) @(negedge clk);
      build(d, v, n);
      eq_bits.push_back(v);
      eq_n.push_back(n);
      sent++;
      wr_en = 1'b1;
      wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      chk(!tbe, "R5", "tbe after write", tbe, 0);
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (!(tsc && tbe)) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   // line monitor: decodes frames at mid-bit and compares with expectation
   initial begin : mon
      logic last;
      logic [11:0] got, ev;
      int n;
      last = 1'b1;
      forever begin
         @(negedge clk);
         if (rst_n && last && !txd) begin
            start_cyc.push_back(cyc);
            if (eq_n.size() == 0) begin
               chk(1'b0, "R2", "unexpected start bit", 0, 1);
               last = txd;
            end else begin
               ev = eq_bits.pop_front();
               n = eq_n.pop_front();
               got = '1;
               repeat (HALF) @(negedge clk);
               got[0] = txd;
               for (int k = 1; k < n; k++) begin
                  repeat (BIT) @(negedge clk);
                  got[k] = txd;
               end
               chk(got == ev, "R2 R3 R4", "frame bits", int'(got), int'(ev));
               frames_seen++;
               last = 1'b1;
            end
         end else begin
            last = txd;
         end
      end
   end

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired: actual hang expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      int k, t0, n, i0, r0;
      logic [11:0] v;
      void'($urandom(32'd4711));
      repeat (5) @(negedge clk);
      // R1 reset state
      chk(txd == 1'b1, "R1", "txd in reset", txd, 1);
      chk(tbe == 1'b1 && tsc == 1'b1, "R1", "flags in reset", {tbe, tsc}, 3);
      chk(tx_irq == 1'b0, "R1", "irq in reset", tx_irq, 0);
      rst_n = 1'b1;
      repeat (7) @(negedge clk);
      chk(txd && tbe && tsc && !tx_irq, "R1", "state after reset",
          {txd, tbe, tsc, tx_irq}, 4'hE);

      // R6 load latency, R7 frame end, 8 data + odd parity + 1 stop
      cfg_par_en = 1'b1; cfg_par_odd = 1'b1;
      send(8'hA5);
      k = 1;
      while (tsc) begin @(negedge clk); k++; end
      chk(k >= 2 && k <= BIT + 1, "R6", "tsc fall latency", k, BIT);
      chk(tbe == 1'b1, "R6", "tbe rises with tsc fall", tbe, 1);
      build(8'hA5, v, n);
      t0 = cyc;
      while (!tsc) @(negedge clk);
      chk(cyc - t0 == n * BIT, "R7", "busy duration", cyc - t0, n * BIT);
      chk(txd == 1'b1, "R7", "line high at done", txd, 1);
      wait_idle();

      // R8 back-to-back, 7 data even parity 2 stop, irq from tsc
      cfg_len8 = 1'b0; cfg_par_odd = 1'b0; cfg_two_stop = 1'b1;
      cfg_irq_on_tsc = 1'b1;
      i0 = irq_cnt; r0 = tsc_rises;
      send(8'hF3);
      send(8'h0C);
      wait_idle();
      build(8'h0C, v, n);
      chk(start_cyc[$] - start_cyc[$-1] == n * BIT, "R8", "start spacing",
          start_cyc[$] - start_cyc[$-1], n * BIT);
      chk(tsc_rises - r0 == 1, "R8", "tsc rises over chain", tsc_rises - r0, 1);
      chk(irq_cnt - i0 == 1, "R9", "tsc irq over chain", irq_cnt - i0, 1);

      // R9 buffer-empty source: three chained frames give three pulses
      cfg_irq_on_tsc = 1'b0; cfg_par_en = 1'b0; cfg_two_stop = 1'b0;
      i0 = irq_cnt;
      send(8'h81); send(8'h7E); send(8'h00);
      wait_idle();
      chk(irq_cnt - i0 == 3, "R9", "tbe irq count", irq_cnt - i0, 3);

      // R9 shift-complete source with isolated frames
      cfg_irq_on_tsc = 1'b1; cfg_len8 = 1'b1;
      i0 = irq_cnt;
      send(8'hFF); wait_idle();
      send(8'h80); wait_idle();
      chk(irq_cnt - i0 == 2, "R9", "tsc irq isolated", irq_cnt - i0, 2);

      // random formats, data and gaps
      for (int f = 0; f < 28; f++) begin
         if (f % 4 == 0) begin
            wait_idle();
            {cfg_len8, cfg_par_en, cfg_par_odd, cfg_two_stop, cfg_irq_on_tsc} =
               5'($urandom_range(0, 31));
         end
         if ($urandom_range(0, 2) == 0) repeat ($urandom_range(0, 500)) @(negedge clk);
         send(8'($urandom_range(0, 255)));
      end
      wait_idle();
      repeat (BIT) @(negedge clk);
      chk(frames_seen == sent, "R2", "frames decoded", frames_seen, sent);
      chk(eq_n.size() == 0, "R2", "pending frames", eq_n.size(), 0);
      chk(txd && tsc && tbe, "R7", "idle at end", {txd, tsc, tbe}, 7);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule